// File: doc/BRIEF.md
# Hardware Cursor Overlay Unit

This block lays a 64 by 64 pixel cursor image over a raster pixel stream. Each cursor pixel is coded by two bits, A and B. Depending on that pair, the block passes the screen pixel through, inverts it bit by bit, or replaces it with one of two programmable solid colours. The host loads the image word by word into an internal pattern buffer through a dedicated write port. It sets the cursor position, the hot-spot, the colours and the mode through a small byte-wide register port.

On every pixel clock the raster logic presents the current X/Y coordinate and the screen pixel. One clock later the block returns the mixed pixel. A double-width mode serves 16-bit colour displays. In that mode a pattern word carries 8 A bits in its upper byte and 8 B bits in its lower byte, each stored bit covers two adjacent screen pixels, and the programmed X position is read as twice the real pixel coordinate. Fetching the pattern from video memory, timing generation and palette lookup are handled elsewhere.

Top module: `cursor_overlay`

## Requirements
- R1: While `rstN` is low, `pixOut` is 0. All host registers clear to 0, so after reset the cursor is disabled and the stream passes through unchanged.
- R2: `pixOut` is registered. The value seen after a rising clock edge depends only on `rasterX`, `rasterY` and `pixIn` sampled at that edge, and it does not change between edges.
- R3: Control register bit 0 enables the cursor. While it is 0, `pixOut` equals the previous cycle's `pixIn` for every coordinate.
- R4: A coordinate outside the 64x64 window (X below the left edge or at left+64 and beyond; the same rule applies to Y) produces the unchanged screen pixel.
- R5: Inside the window, a pixel with A=1 and B=0 outputs the screen pixel unchanged.
- R6: Inside the window, a pixel with A=1 and B=1 outputs the bitwise inverse of the screen pixel.
- R7: Inside the window, a pixel with A=0 outputs the foreground colour when B=1 and the background colour when B=0.
- R8: Normal layout (control bit 1 clear). Cursor row r and column c (0..63) use A bit 15-(c mod 16) of word 8r+2(c div 16) and the B bit at the same position of word 8r+2(c div 16)+1. The MSB of a word is the leftmost pixel.
- R9: Double layout (control bit 1 set). Let s = c div 2. Row r takes both bits from word 4r+(s div 8): A is bit 15-(s mod 8) in the upper byte and B is bit 7-(s mod 8) in the lower byte.
- R10: The window's left edge is Xeff-hotX and its top edge is Ypos-hotY, each clamped at 0. Xeff is the 16-bit X position, halved in double layout.
- R11: Register addresses on `regAddr`: 0 control (bit 0 enable, bit 1 double layout); 1 X high byte; 2 X low byte; 3 Y high byte; 4 Y low byte; 5 hot-spot X; 6 hot-spot Y; 8 and 9 foreground low and high byte; 12 and 13 background low and high byte.
- R12: A `patWe` pulse writes `patWdata` into pattern word `patAddr`. The word affects the overlay from the second clock after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Host register write strobe |
| regAddr | input | 4 | Host register address |
| regWdata | input | 8 | Host register write byte |
| patWe | input | 1 | Pattern word write strobe |
| patAddr | input | 9 | Pattern word address |
| patWdata | input | 16 | Pattern word data |
| rasterX | input | 16 | Current raster X coordinate |
| rasterY | input | 16 | Current raster Y coordinate |
| pixIn | input | 16 | Screen pixel at the current coordinate |
| pixOut | output | 16 | Mixed pixel, one clock later |

## Verification
On every cycle the assertions tie the selected mix to the next output: screen pass-through (also when disabled or outside the window), inversion, and the two solid colours. They also check that register and pattern writes land on the strobe path. Two things can only be shown by the bench's scenarios, because each needs a known image and a known position together. The first is the mapping of raster coordinates to pattern words and bit positions in both layouts. The second is window placement with hot-spot subtraction, clamping at zero and the halved X position.

// File: rtl/cursor_ovl_pkg.sv
package cursor_ovl_pkg;
  localparam int PIX_W       = 16;
  localparam int COORD_W     = 16;
  localparam int HOT_W       = 8;
  localparam int CUR_DIM     = 64;
  localparam int CUR_LOG     = $clog2(CUR_DIM);
  localparam int PAT_WORD_W  = 16;
  localparam int BIT_LOG     = $clog2(PAT_WORD_W);
  localparam int ROW_WORDS   = 2 * CUR_DIM / PAT_WORD_W;
  localparam int PAT_DEPTH   = CUR_DIM * ROW_WORDS;
  localparam int PAT_ADDR_W  = $clog2(PAT_DEPTH);
  localparam int REG_ADDR_W  = 4;
  localparam int CLR_BYTES   = (PIX_W + 7) / 8;

  localparam int RA_CTRL = 0;
  localparam int RA_XHI  = 1;
  localparam int RA_XLO  = 2;
  localparam int RA_YHI  = 3;
  localparam int RA_YLO  = 4;
  localparam int RA_HOTX = 5;
  localparam int RA_HOTY = 6;
  localparam int RA_FG0  = 8;
  localparam int RA_BG0  = 12;

  typedef enum logic [1:0] {
    MIX_SCREEN = 2'd0,
    MIX_INVERT = 2'd1,
    MIX_FORE   = 2'd2,
    MIX_BACK   = 2'd3
  } mix_e;

  typedef struct packed {
    logic               enable;
    logic               dblMode;
    logic [COORD_W-1:0] posX;
    logic [COORD_W-1:0] posY;
    logic [HOT_W-1:0]   hotX;
    logic [HOT_W-1:0]   hotY;
    logic [PIX_W-1:0]   fgColor;
    logic [PIX_W-1:0]   bgColor;
  } cursor_cfg_t;

  typedef struct packed {
    logic                  patWr;
    logic [PAT_ADDR_W-1:0] patAddr;
    logic [PAT_WORD_W-1:0] patData;
  } pat_strobe_t;
endpackage

// File: rtl/cursor_ovl_ctrl.sv
module cursor_ovl_ctrl
  import cursor_ovl_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWe,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [7:0]            regWdata,
  input  logic                  patWe,
  input  logic [PAT_ADDR_W-1:0] patAddr,
  input  logic [PAT_WORD_W-1:0] patWdata,
  output cursor_cfg_t           cfg,
  output pat_strobe_t           patStb
);
  logic [1:0]               ctrlReg;
  logic [COORD_W-1:0]       posXReg;
  logic [COORD_W-1:0]       posYReg;
  logic [HOT_W-1:0]         hotXReg;
  logic [HOT_W-1:0]         hotYReg;
  logic [CLR_BYTES*8-1:0]   fgBytes;
  logic [CLR_BYTES*8-1:0]   bgBytes;

  // host byte registers; position split into high and low halves
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      posXReg <= '0;
      posYReg <= '0;
      hotXReg <= '0;
      hotYReg <= '0;
      fgBytes <= '0;
      bgBytes <= '0;
    end else if (regWe) begin
      case (int'(regAddr))
        RA_CTRL: ctrlReg       <= regWdata[1:0];
        RA_XHI:  posXReg[15:8] <= regWdata;
        RA_XLO:  posXReg[7:0]  <= regWdata;
        RA_YHI:  posYReg[15:8] <= regWdata;
        RA_YLO:  posYReg[7:0]  <= regWdata;
        RA_HOTX: hotXReg       <= regWdata;
        RA_HOTY: hotYReg       <= regWdata;
        default: ;
      endcase
      for (int b = 0; b < CLR_BYTES; b++) begin
        if (int'(regAddr) == RA_FG0 + b) fgBytes[b*8 +: 8] <= regWdata;
        if (int'(regAddr) == RA_BG0 + b) bgBytes[b*8 +: 8] <= regWdata;
      end
    end
  end

  // pattern writes are retimed into the strobe struct
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      patStb <= '0;
    end else begin
      patStb.patWr   <= patWe;
      patStb.patAddr <= patAddr;
      patStb.patData <= patWdata;
    end
  end

  always_comb begin
    cfg.enable  = ctrlReg[0];
    cfg.dblMode = ctrlReg[1];
    cfg.posX    = posXReg;
    cfg.posY    = posYReg;
    cfg.hotX    = hotXReg;
    cfg.hotY    = hotYReg;
    cfg.fgColor = fgBytes[PIX_W-1:0];
    cfg.bgColor = bgBytes[PIX_W-1:0];
  end

  // R11: control byte reaches the configuration one clock after the write
  p_ctrl_write_r11: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && int'(regAddr) == RA_CTRL) |=>
      (cfg.enable == $past(regWdata[0]) && cfg.dblMode == $past(regWdata[1])));

  // R12: every host pattern write appears on the strobe path
  p_pat_strobe_r12: assert property (@(posedge clk) disable iff (!rstN)
    patWe |=> (patStb.patWr && patStb.patAddr == $past(patAddr)
               && patStb.patData == $past(patWdata)));
endmodule

// File: rtl/cursor_pattern_ram.sv
module cursor_pattern_ram #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 512,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [AW-1:0]     wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [AW-1:0]     rdAddrA,
  input  logic [AW-1:0]     rdAddrB,
  output logic [WORD_W-1:0] rdDataA,
  output logic [WORD_W-1:0] rdDataB
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
  end

  assign rdDataA = mem[rdAddrA];
  assign rdDataB = mem[rdAddrB];
endmodule

// File: rtl/cursor_ovl_datapath.sv
module cursor_ovl_datapath
  import cursor_ovl_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  cursor_cfg_t        cfg,
  input  pat_strobe_t        patStb,
  input  logic [COORD_W-1:0] rasterX,
  input  logic [COORD_W-1:0] rasterY,
  input  logic [PIX_W-1:0]   pixIn,
  output logic [PIX_W-1:0]   pixOut
);
  localparam int GRP_W = CUR_LOG - BIT_LOG;

  logic [COORD_W-1:0]    posXEff, hotXExt, hotYExt;
  logic [COORD_W-1:0]    winLeft, winTop;
  logic [COORD_W-1:0]    dx, dy;
  logic                  insideWin;
  logic [CUR_LOG-1:0]    lx, ly;
  logic [GRP_W-1:0]      colGrp;
  logic [BIT_LOG-2:0]    subCol;
  logic [PAT_ADDR_W-1:0] normAddrA, dblAddr, rdAddrA, rdAddrB;
  logic [PAT_WORD_W-1:0] wordA, wordB;
  logic [BIT_LOG-1:0]    idxA, idxB;
  logic                  bitA, bitB;
  mix_e                  mixSel;

  // window placement: position minus hot-spot, clamped at zero
  always_comb begin
    posXEff = cfg.dblMode ? (cfg.posX >> 1) : cfg.posX;
    hotXExt = COORD_W'(cfg.hotX);
    hotYExt = COORD_W'(cfg.hotY);
    winLeft = (posXEff > hotXExt) ? posXEff - hotXExt : '0;
    winTop  = (cfg.posY > hotYExt) ? cfg.posY - hotYExt : '0;
    dx      = rasterX - winLeft;
    dy      = rasterY - winTop;
    insideWin = (rasterX >= winLeft) && (dx < COORD_W'(CUR_DIM))
             && (rasterY >= winTop)  && (dy < COORD_W'(CUR_DIM));
    lx      = dx[CUR_LOG-1:0];
    ly      = dy[CUR_LOG-1:0];
  end

  // pattern word addressing for both layouts
  always_comb begin
    colGrp    = lx[CUR_LOG-1:BIT_LOG];
    subCol    = lx[BIT_LOG-1:1];
    normAddrA = {ly, colGrp, 1'b0};
    dblAddr   = {1'b0, ly, colGrp};
    rdAddrA   = cfg.dblMode ? dblAddr : normAddrA;
    rdAddrB   = cfg.dblMode ? dblAddr : (normAddrA | PAT_ADDR_W'(1));
  end

  cursor_pattern_ram #(
    .WORD_W (PAT_WORD_W),
    .DEPTH  (PAT_DEPTH)
  ) i_patRam (
    .clk     (clk),
    .wrEn    (patStb.patWr),
    .wrAddr  (patStb.patAddr),
    .wrData  (patStb.patData),
    .rdAddrA (rdAddrA),
    .rdAddrB (rdAddrB),
    .rdDataA (wordA),
    .rdDataB (wordB)
  );

  // bit select: MSB is the leftmost pixel
  always_comb begin
    if (cfg.dblMode) begin
      idxA = {1'b1, ~subCol};
      idxB = {1'b0, ~subCol};
    end else begin
      idxA = ~lx[BIT_LOG-1:0];
      idxB = ~lx[BIT_LOG-1:0];
    end
    bitA = wordA[idxA];
    bitB = wordB[idxB];
  end

  always_comb begin
    if (!cfg.enable || !insideWin) begin
      mixSel = MIX_SCREEN;
    end else begin
      case ({bitA, bitB})
        2'b11:   mixSel = MIX_INVERT;
        2'b10:   mixSel = MIX_SCREEN;
        2'b01:   mixSel = MIX_FORE;
        default: mixSel = MIX_BACK;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixOut <= '0;
    end else begin
      case (mixSel)
        MIX_INVERT: pixOut <= ~pixIn;
        MIX_FORE:   pixOut <= cfg.fgColor;
        MIX_BACK:   pixOut <= cfg.bgColor;
        default:    pixOut <= pixIn;
      endcase
    end
  end

  // R3: disabled cursor passes the stream with one clock of delay
  p_disabled_pass_r3: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.enable |=> pixOut == $past(pixIn));

  // R4: coordinates outside the window leave the pixel alone
  p_outside_pass_r4: assert property (@(posedge clk) disable iff (!rstN)
    !insideWin |=> pixOut == $past(pixIn));

  // R5: transparent code
  p_screen_r5: assert property (@(posedge clk) disable iff (!rstN)
    (mixSel == MIX_SCREEN) |=> pixOut == $past(pixIn));

  // R6: inverting code
  p_invert_r6: assert property (@(posedge clk) disable iff (!rstN)
    (mixSel == MIX_INVERT) |=> pixOut == ~$past(pixIn));

  // R7: solid foreground
  p_fore_r7: assert property (@(posedge clk) disable iff (!rstN)
    (mixSel == MIX_FORE) |=> pixOut == $past(cfg.fgColor));

  // R7: solid background
  p_back_r7: assert property (@(posedge clk) disable iff (!rstN)
    (mixSel == MIX_BACK) |=> pixOut == $past(cfg.bgColor));
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_ovl_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWe,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [7:0]            regWdata,
  input  logic                  patWe,
  input  logic [PAT_ADDR_W-1:0] patAddr,
  input  logic [PAT_WORD_W-1:0] patWdata,
  input  logic [COORD_W-1:0]    rasterX,
  input  logic [COORD_W-1:0]    rasterY,
  input  logic [PIX_W-1:0]      pixIn,
  output logic [PIX_W-1:0]      pixOut
);
  cursor_cfg_t cfg;
  pat_strobe_t patStb;

  cursor_ovl_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .patWe    (patWe),
    .patAddr  (patAddr),
    .patWdata (patWdata),
    .cfg      (cfg),
    .patStb   (patStb)
  );

  cursor_ovl_datapath i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .cfg     (cfg),
    .patStb  (patStb),
    .rasterX (rasterX),
    .rasterY (rasterY),
    .pixIn   (pixIn),
    .pixOut  (pixOut)
  );
endmodule

// File: tb/test_cursor_overlay.sv
module test_cursor_overlay;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [7:0]  regWdata = '0;
  logic        patWe = 1'b0;
  logic [8:0]  patAddr = '0;
  logic [15:0] patWdata = '0;
  logic [15:0] rasterX = '0;
  logic [15:0] rasterY = '0;
  logic [15:0] pixIn = '0;
  logic [15:0] pixOut;

  int nChecks = 0;
  int nFails  = 0;

  localparam logic [15:0] FG = 16'h1234;
  localparam logic [15:0] BG = 16'hABCD;

  // {x, y, pix, code}; code 0 screen, 1 inverse, 2 foreground, 3 background
  // window at left 96, top 48 (X 100, Y 50, hot-spot 4/2), normal layout
  localparam int NVEC = 14;
  localparam logic [49:0] VEC [NVEC] = '{
    {16'd95,  16'd48,  16'h0F0F, 2'd0},
    {16'd96,  16'd48,  16'h1357, 2'd1},
    {16'd98,  16'd48,  16'h2468, 2'd0},
    {16'd100, 16'd49,  16'h5555, 2'd2},
    {16'd102, 16'd50,  16'hAAAA, 2'd3},
    {16'd105, 16'd51,  16'h00FF, 2'd1},
    {16'd109, 16'd52,  16'h8001, 2'd2},
    {16'd146, 16'd48,  16'h7777, 2'd1},
    {16'd159, 16'd111, 16'hC3C3, 2'd1},
    {16'd160, 16'd60,  16'h9999, 2'd0},
    {16'd120, 16'd112, 16'h4242, 2'd0},
    {16'd103, 16'd53,  16'h6666, 2'd2},
    {16'd118, 16'd60,  16'h3C3C, 2'd3},
    {16'd115, 16'd70,  16'hBEEF, 2'd0}
  };

  cursor_overlay i_cursor_overlay (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .patWe(patWe), .patAddr(patAddr), .patWdata(patWdata),
    .rasterX(rasterX), .rasterY(rasterY), .pixIn(pixIn), .pixOut(pixOut)
  );

  always #5 clk = ~clk;

  function automatic logic [15:0] expOf(input logic [1:0] code, input logic [15:0] pix);
    case (code)
      2'd1:    return ~pix;
      2'd2:    return FG;
      2'd3:    return BG;
      default: return pix;
    endcase
  endfunction

  // normal layout image: row 5 all foreground, column group 3 all inverse
  function automatic logic [15:0] normWord(input int a);
    int r = a >> 3;
    int w = a & 7;
    if (r == 5) return (w & 1) ? 16'hFFFF : 16'h0000;
    if ((w >> 1) == 3) return 16'hFFFF;
    return (w & 1) ? 16'hCCCC : 16'hF0F0;
  endfunction

  // double layout image: A byte high, B byte low; group 2 all inverse
  function automatic logic [15:0] dblWord(input int a);
    return ((a & 3) == 2) ? 16'hFFFF : 16'hF0CC;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: pixOut=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWr(input int addr, input logic [7:0] data);
    regWe = 1'b1; regAddr = 4'(addr); regWdata = data;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic setPlace(input logic [15:0] x, input logic [15:0] y,
                          input logic [7:0] hx, input logic [7:0] hy);
    regWr(1, x[15:8]); regWr(2, x[7:0]);
    regWr(3, y[15:8]); regWr(4, y[7:0]);
    regWr(5, hx);      regWr(6, hy);
  endtask

  task automatic loadPattern(input bit dbl);
    for (int a = 0; a < (dbl ? 256 : 512); a++) begin
      patWe = 1'b1; patAddr = 9'(a);
      patWdata = dbl ? dblWord(a) : normWord(a);
      @(negedge clk);
    end
    patWe = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // drive at a falling edge, sample at the next falling edge (one register)
  task automatic probe(input string req, input logic [15:0] x, input logic [15:0] y,
                       input logic [15:0] pix, input logic [1:0] code);
    rasterX = x; rasterY = y; pixIn = pix;
    @(negedge clk);
    check(req, pixOut, expOf(code, pix));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: pixOut=%h expected=completion", pixOut);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    // R1: output held at zero during reset
    pixIn = 16'hFFFF;
    repeat (3) @(negedge clk);
    check("R1 reset output", pixOut, 16'h0000);
    rstN = 1'b1;
    @(negedge clk);
    // R1/R3: registers cleared, cursor disabled, pass-through
    probe("R1 disabled after reset", 16'd0, 16'd0, 16'h5A5A, 2'd0);

    // R11: register map; R12: pattern load
    regWr(8, FG[7:0]);  regWr(9, FG[15:8]);
    regWr(12, BG[7:0]); regWr(13, BG[15:8]);
    setPlace(16'd100, 16'd50, 8'd4, 8'd2);
    loadPattern(1'b0);

    // R3: still disabled inside the window
    probe("R3 disabled", 16'd96, 16'd48, 16'h1357, 2'd0);
    regWr(0, 8'h01);

    // R4..R8, R10: vector table in normal layout
    for (int i = 0; i < NVEC; i++) begin
      string tag;
      case (VEC[i][1:0])
        2'd1:    tag = "R6 invert";
        2'd2:    tag = "R7 foreground";
        2'd3:    tag = "R7 background";
        default: tag = "R4/R5 screen";
      endcase
      probe($sformatf("%s R8 vec%0d", tag, i), VEC[i][49:34], VEC[i][33:18],
            VEC[i][17:2], VEC[i][1:0]);
    end

    // R2: output is registered; a new input does not show before the edge
    rasterX = 16'd96; rasterY = 16'd48; pixIn = 16'h0001;
    @(negedge clk);
    pixIn = 16'h0F00; rasterX = 16'd98;
    #1;
    check("R2 held until edge", pixOut, 16'hFFFE);
    @(negedge clk);
    check("R2 one clock", pixOut, 16'h0F00);

    // R10: clamp at zero when hot-spot exceeds position
    setPlace(16'd2, 16'd1, 8'd5, 8'd3);
    probe("R10 clamp origin", 16'd0, 16'd0, 16'h1111, 2'd1);
    probe("R10 clamp col2", 16'd2, 16'd0, 16'h2222, 2'd0);
    probe("R10 clamp right edge", 16'd64, 16'd0, 16'h3333, 2'd0);

    // R9: double layout with doubled X position (200 -> 100, left 96)
    regWr(0, 8'h03);
    setPlace(16'd200, 16'd50, 8'd4, 8'd2);
    loadPattern(1'b1);
    probe("R9 dbl lx0",  16'd96,  16'd48, 16'h4444, 2'd1);
    probe("R9 dbl lx3",  16'd99,  16'd48, 16'h4545, 2'd1);
    probe("R9 dbl lx4",  16'd100, 16'd48, 16'h4646, 2'd0);
    probe("R9 dbl lx8",  16'd104, 16'd48, 16'h4747, 2'd2);
    probe("R9 dbl lx13", 16'd109, 16'd48, 16'h4848, 2'd3);
    probe("R9 dbl lx28", 16'd124, 16'd48, 16'h4949, 2'd3);
    probe("R9 dbl lx36", 16'd132, 16'd48, 16'h4A4A, 2'd1);
    probe("R10 dbl right outside", 16'd160, 16'd48, 16'h4B4B, 2'd0);

    // R3: disable again while in double layout
    regWr(0, 8'h02);
    probe("R3 disabled dbl", 16'd96, 16'd48, 16'h4C4C, 2'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule